// File: doc/BRIEF.md
# Repeat-Loop and Breakpoint Next-PC Sequencer

This block sits behind the execute stage of a small processor core and decides where the program counter goes next. Each time an instruction retires, it chooses among four targets: the next sequential word, a branch target reported by execute, the start of a zero-overhead hardware loop, or the debug trap vector. It holds the program counter, the remaining repeat count, a status word and a pair of save registers. The status word carries a repeat-active flag, a debug-enable flag and a supervisor-mode bit.

The loop bounds and the breakpoint address come in as inputs from the core's register file. Execute loads the count and the status word through a single control write port. When the retiring instruction sits at the loop end address, the block jumps back to the loop start and decrements the count. On the final pass it clears the repeat flag and falls through instead. A taken branch at the loop end wins over looping. A breakpoint hit with debug enabled beats both: the block saves the PC and the status word, reduces the status word to its supervisor-mode bit, vectors to the trap address and pulses a trap strobe.

Top module: `zol_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the PC is 0xFFC0. The count, status word, both save registers and the trap strobe are all zero.
- R2: In a cycle with neither retire nor control write, the PC, count and status word keep their values, and the trap strobe is low in the following cycle.
- R3: A control write loads the count and the status word in the next cycle and leaves the PC unchanged. This holds even when retire and branch-taken are asserted in the same cycle.
- R4: A retiring instruction that takes no branch and sets up no loop or trap advances the PC by one, wrapping modulo 2^AW. Loop-end and breakpoint matches have no effect while the repeat flag (status bit 0) or debug flag (status bit 12) is clear.
- R5: With the repeat flag set, the PC equal to the loop-end input, a count above 1, no branch and no trap, the next PC is the loop-start input and the count drops by one.
- R6: At the loop end with the repeat flag set and a count of 1 or 0 (no branch, no trap), the PC falls through to PC+1, the count becomes 0 and the repeat flag clears.
- R7: A taken branch, including one at the loop end, loads the branch target into the PC. The count and status word stay unchanged and no loop is applied.
- R8: With debug enabled and the PC equal to the breakpoint input, the next PC is the trap vector 0x3FF0, overriding any branch or loop. The count is unchanged and the trap strobe is high for exactly one cycle.
- R9: On a trap, the status word keeps only its supervisor-mode bit (bit 15). The save registers capture the trapped PC and the status word as it stood before the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | The instruction at the current PC completes this cycle |
| br_taken_i | input | 1 | The retiring instruction redirected the PC |
| br_target_i | input | AW | Branch target word address |
| rpt_start_i | input | AW | Loop start word address |
| rpt_end_i | input | AW | Loop end word address |
| brk_addr_i | input | AW | Instruction breakpoint word address |
| ctl_we_i | input | 1 | Load the count and the status word |
| ctl_count_i | input | CW | Count value to load |
| ctl_status_i | input | SW | Status word to load |
| pc_o | output | AW | Current program counter |
| rpt_count_o | output | CW | Remaining repeat count |
| status_o | output | SW | Status word |
| trap_o | output | 1 | Debug trap strobe, one cycle |
| save_pc_o | output | AW | PC captured on the last trap |
| save_status_o | output | SW | Status word captured on the last trap |

## Verification
The hardest state to reach is one where a branch, a loop end and a breakpoint all fall on the same PC with both flags set. That is the only state in which the full priority order can be seen. Every vector builds it in three steps. First, a taken branch is issued with all flags clear, which places the PC anywhere without side effects. Next, a control write loads the count and flags. Finally, the loop-end and breakpoint inputs are aimed at that PC before the instruction under test retires. A separate directed run takes a three-pass loop through every iteration to its fall-through exit.

// File: rtl/zol_pkg.sv
package zol_pkg;
   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_LOOP   = 2'd2,
      NPC_TRAP   = 2'd3
   } npc_src_e;
endpackage

// File: rtl/zol_addr_match.sv
module zol_addr_match #(
   parameter int AW = 16,
   parameter bit EN = 1'b1
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output logic          hit_o
);
   generate
      if (EN) begin : g_on
         assign hit_o = (a_i == b_i);
      end else begin : g_off
         assign hit_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/zol_loop_ctl.sv
module zol_loop_ctl #(
   parameter int CW = 16
) (
   input  logic          rpt_on_i,
   input  logic          at_end_i,
   input  logic [CW-1:0] count_i,
   output logic          jump_o,
   output logic          exit_o,
   output logic [CW-1:0] count_o
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic armed;
   assign armed  = rpt_on_i & at_end_i;
   assign jump_o = armed & (count_i > ONE);
   assign exit_o = armed & (count_i <= ONE);

   always_comb begin
      if (jump_o)      count_o = count_i - ONE;
      else if (exit_o) count_o = '0;
      else             count_o = count_i;
   end
endmodule

// File: rtl/zol_npc_sel.sv
module zol_npc_sel
   import zol_pkg::*;
#(
   parameter int             AW       = 16,
   parameter logic [AW-1:0]  TRAP_VEC = 16'h3FF0
) (
   input  logic [AW-1:0] pc_i,
   input  logic          trap_i,
   input  logic          br_taken_i,
   input  logic [AW-1:0] br_target_i,
   input  logic          loop_jump_i,
   input  logic [AW-1:0] rpt_start_i,
   output npc_src_e      src_o,
   output logic [AW-1:0] npc_o
);
   always_comb begin
      if (trap_i)           src_o = NPC_TRAP;
      else if (br_taken_i)  src_o = NPC_BRANCH;
      else if (loop_jump_i) src_o = NPC_LOOP;
      else                  src_o = NPC_SEQ;
   end

   always_comb begin
      unique case (src_o)
         NPC_TRAP:   npc_o = TRAP_VEC;
         NPC_BRANCH: npc_o = br_target_i;
         NPC_LOOP:   npc_o = rpt_start_i;
         default:    npc_o = pc_i + 1'b1;
      endcase
   end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
   import zol_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            CW       = 16,
   parameter int            SW       = 16,
   parameter logic [AW-1:0] RESET_PC = 16'hFFC0,
   parameter logic [AW-1:0] TRAP_VEC = 16'h3FF0,
   parameter int            RP_BIT   = 0,
   parameter int            DB_BIT   = 12,
   parameter int            SM_BIT   = 15,
   parameter bit            BRK_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          retire_i,
   input  logic          br_taken_i,
   input  logic [AW-1:0] br_target_i,
   input  logic [AW-1:0] rpt_start_i,
   input  logic [AW-1:0] rpt_end_i,
   input  logic [AW-1:0] brk_addr_i,
   input  logic          ctl_we_i,
   input  logic [CW-1:0] ctl_count_i,
   input  logic [SW-1:0] ctl_status_i,
   output logic [AW-1:0] pc_o,
   output logic [CW-1:0] rpt_count_o,
   output logic [SW-1:0] status_o,
   output logic          trap_o,
   output logic [AW-1:0] save_pc_o,
   output logic [SW-1:0] save_status_o
);
   localparam logic [SW-1:0] SM_MASK = {{(SW-1){1'b0}}, 1'b1} << SM_BIT;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("zol_seq: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("zol_seq: CW must be at least 1");
      end
      if (RP_BIT >= SW || DB_BIT >= SW || SM_BIT >= SW) begin : g_bad_bits
         $error("zol_seq: status bit position outside status word");
      end
      if (RP_BIT == DB_BIT || RP_BIT == SM_BIT || DB_BIT == SM_BIT) begin : g_dup_bits
         $error("zol_seq: status bit positions must differ");
      end
   endgenerate

   logic [AW-1:0] pc_q, save_pc_q, npc;
   logic [CW-1:0] cnt_q, cnt_loop;
   logic [SW-1:0] st_q, save_st_q;
   logic          trap_q;
   logic          end_hit, brk_hit, trap_hit, loop_jump, loop_exit;
   npc_src_e      src;

   zol_addr_match #(.AW(AW), .EN(1'b1)) u_end_cmp (
      .a_i  (pc_q),
      .b_i  (rpt_end_i),
      .hit_o(end_hit)
   );

   zol_addr_match #(.AW(AW), .EN(BRK_EN)) u_brk_cmp (
      .a_i  (pc_q),
      .b_i  (brk_addr_i),
      .hit_o(brk_hit)
   );

   assign trap_hit = st_q[DB_BIT] & brk_hit;

   zol_loop_ctl #(.CW(CW)) u_loop (
      .rpt_on_i(st_q[RP_BIT]),
      .at_end_i(end_hit),
      .count_i (cnt_q),
      .jump_o  (loop_jump),
      .exit_o  (loop_exit),
      .count_o (cnt_loop)
   );

   zol_npc_sel #(.AW(AW), .TRAP_VEC(TRAP_VEC)) u_sel (
      .pc_i       (pc_q),
      .trap_i     (trap_hit),
      .br_taken_i (br_taken_i),
      .br_target_i(br_target_i),
      .loop_jump_i(loop_jump),
      .rpt_start_i(rpt_start_i),
      .src_o      (src),
      .npc_o      (npc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= RESET_PC;
         cnt_q     <= '0;
         st_q      <= '0;
         save_pc_q <= '0;
         save_st_q <= '0;
         trap_q    <= 1'b0;
      end else if (ctl_we_i) begin
         cnt_q  <= ctl_count_i;
         st_q   <= ctl_status_i;
         trap_q <= 1'b0;
      end else if (retire_i) begin
         pc_q   <= npc;
         trap_q <= (src == NPC_TRAP);
         unique case (src)
            NPC_TRAP: begin
               save_pc_q <= pc_q;
               save_st_q <= st_q;
               st_q      <= st_q & SM_MASK;
            end
            NPC_BRANCH: ;
            default: begin
               cnt_q <= cnt_loop;
               if (loop_exit) st_q[RP_BIT] <= 1'b0;
            end
         endcase
      end else begin
         trap_q <= 1'b0;
      end
   end

   assign pc_o          = pc_q;
   assign rpt_count_o   = cnt_q;
   assign status_o      = st_q;
   assign trap_o        = trap_q;
   assign save_pc_o     = save_pc_q;
   assign save_status_o = save_st_q;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
   parameter int            AW       = 16,
   parameter int            CW       = 16,
   parameter int            SW       = 16,
   parameter logic [AW-1:0] TRAP_VEC = 16'h3FF0,
   parameter int            RP_BIT   = 0,
   parameter int            DB_BIT   = 12,
   parameter int            SM_BIT   = 15,
   parameter bit            BRK_EN   = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          retire_i,
   input logic          br_taken_i,
   input logic [AW-1:0] br_target_i,
   input logic [AW-1:0] rpt_start_i,
   input logic [AW-1:0] rpt_end_i,
   input logic [AW-1:0] brk_addr_i,
   input logic          ctl_we_i,
   input logic [CW-1:0] ctl_count_i,
   input logic [SW-1:0] ctl_status_i,
   input logic [AW-1:0] pc_o,
   input logic [CW-1:0] rpt_count_o,
   input logic [SW-1:0] status_o,
   input logic          trap_o,
   input logic [AW-1:0] save_pc_o,
   input logic [SW-1:0] save_status_o
);
   localparam logic [SW-1:0] SM_MASK = {{(SW-1){1'b0}}, 1'b1} << SM_BIT;
   localparam logic [CW-1:0] ONE     = CW'(1);

   logic adv, trap_c, end_c;
   assign adv    = retire_i & ~ctl_we_i;
   assign trap_c = BRK_EN & status_o[DB_BIT] & (pc_o == brk_addr_i);
   assign end_c  = status_o[RP_BIT] & (pc_o == rpt_end_i);

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!retire_i && !ctl_we_i) |=> ($stable(pc_o) && $stable(rpt_count_o) && $stable(status_o) && !trap_o)); // R2

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_i |=> (rpt_count_o == $past(ctl_count_i) && status_o == $past(ctl_status_i) && $stable(pc_o))); // R3

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !trap_c && !br_taken_i && !end_c) |=> (pc_o == $past(pc_o) + 1'b1)); // R4

   AST_LOOP_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !trap_c && !br_taken_i && end_c && rpt_count_o > ONE)
      |=> (pc_o == $past(rpt_start_i) && rpt_count_o == $past(rpt_count_o) - ONE)); // R5

   AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !trap_c && !br_taken_i && end_c && rpt_count_o <= ONE)
      |=> (pc_o == $past(pc_o) + 1'b1 && rpt_count_o == '0 && !status_o[RP_BIT])); // R6

   AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !trap_c && br_taken_i) |=> (pc_o == $past(br_target_i) && $stable(rpt_count_o) && $stable(status_o))); // R7

   AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && trap_c) |=> (pc_o == TRAP_VEC && trap_o && $stable(rpt_count_o))); // R8

   AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && trap_c) |=> (status_o == ($past(status_o) & SM_MASK) && save_status_o == $past(status_o)
                           && save_pc_o == $past(pc_o))); // R9
endmodule

bind zol_seq zol_seq_chk #(
   .AW(AW), .CW(CW), .SW(SW), .TRAP_VEC(TRAP_VEC),
   .RP_BIT(RP_BIT), .DB_BIT(DB_BIT), .SM_BIT(SM_BIT), .BRK_EN(BRK_EN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .br_taken_i(br_taken_i),
   .br_target_i(br_target_i), .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
   .brk_addr_i(brk_addr_i), .ctl_we_i(ctl_we_i), .ctl_count_i(ctl_count_i),
   .ctl_status_i(ctl_status_i), .pc_o(pc_o), .rpt_count_o(rpt_count_o),
   .status_o(status_o), .trap_o(trap_o), .save_pc_o(save_pc_o),
   .save_status_o(save_status_o)
);

// File: tb/zol_seq_tb_top.sv
`timescale 1ns/1ps
module zol_seq_tb_top;
   localparam logic [15:0] LOOP_START = 16'h0100;
   localparam logic [15:0] TVEC       = 16'h3FF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 1'b0, br_taken_i = 1'b0, ctl_we_i = 1'b0;
   logic [15:0] br_target_i = '0, rpt_start_i = LOOP_START, rpt_end_i = '0, brk_addr_i = '0;
   logic [15:0] ctl_count_i = '0, ctl_status_i = '0;
   logic [15:0] pc_o, rpt_count_o, status_o, save_pc_o, save_status_o;
   logic        trap_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   zol_seq dut_i (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .br_taken_i(br_taken_i),
      .br_target_i(br_target_i), .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
      .brk_addr_i(brk_addr_i), .ctl_we_i(ctl_we_i), .ctl_count_i(ctl_count_i),
      .ctl_status_i(ctl_status_i), .pc_o(pc_o), .rpt_count_o(rpt_count_o),
      .status_o(status_o), .trap_o(trap_o), .save_pc_o(save_pc_o),
      .save_status_o(save_status_o)
   );

   typedef struct packed {
      logic [15:0] pc0;
      logic [15:0] st;
      logic [15:0] cnt;
      logic [15:0] rend;
      logic [15:0] brk;
      logic        br;
      logic [15:0] tgt;
      logic [15:0] e_pc;
      logic [15:0] e_cnt;
      logic [15:0] e_st;
      logic        e_trap;
   } vec_t;

   // status bits: 0 repeat, 12 debug, 15 supervisor
   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{16'h0200, 16'h0000, 16'h0005, 16'h0200, 16'h0200, 1'b0, 16'h0000, 16'h0201, 16'h0005, 16'h0000, 1'b0}, // R4 flags off
      '{16'h0210, 16'h0001, 16'h0005, 16'h0210, 16'h0000, 1'b0, 16'h0000, 16'h0100, 16'h0004, 16'h0001, 1'b0}, // R5
      '{16'h0210, 16'h0001, 16'h0001, 16'h0210, 16'h0000, 1'b0, 16'h0000, 16'h0211, 16'h0000, 16'h0000, 1'b0}, // R6
      '{16'h0210, 16'h0001, 16'h0005, 16'h0300, 16'h0000, 1'b0, 16'h0000, 16'h0211, 16'h0005, 16'h0001, 1'b0}, // R4 not at end
      '{16'h0210, 16'h0001, 16'h0005, 16'h0210, 16'h0000, 1'b1, 16'h0456, 16'h0456, 16'h0005, 16'h0001, 1'b0}, // R7
      '{16'h0220, 16'h9001, 16'h0003, 16'h0220, 16'h0220, 1'b1, 16'h0500, TVEC,     16'h0003, 16'h8000, 1'b1}, // R8 R9
      '{16'h0230, 16'h1000, 16'h0002, 16'h0000, 16'h0230, 1'b0, 16'h0000, TVEC,     16'h0002, 16'h0000, 1'b1}, // R9 no SM
      '{16'h0240, 16'h1000, 16'h0002, 16'h0000, 16'h0241, 1'b0, 16'h0000, 16'h0241, 16'h0002, 16'h1000, 1'b0}, // R4 brk miss
      '{16'h0250, 16'h0001, 16'h0000, 16'h0250, 16'h0000, 1'b0, 16'h0000, 16'h0251, 16'h0000, 16'h0000, 1'b0}, // R6 count 0
      '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R4 wrap
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic do_ctl(input logic [15:0] cnt, input logic [15:0] st);
      @(negedge clk);
      ctl_we_i = 1'b1; ctl_count_i = cnt; ctl_status_i = st;
      @(negedge clk);
      ctl_we_i = 1'b0;
   endtask

   task automatic do_retire(input logic br, input logic [15:0] tgt);
      @(negedge clk);
      retire_i = 1'b1; br_taken_i = br; br_target_i = tgt;
      @(negedge clk);
      retire_i = 1'b0; br_taken_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", 32'(pc_o), 32'h0000FFC0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pc", 32'(pc_o), 32'h0000FFC0);
      chk("R1 count", 32'(rpt_count_o), 32'h0);
      chk("R1 status", 32'(status_o), 32'h0);
      chk("R1 trap", 32'(trap_o), 32'h0);
      chk("R1 save_pc", 32'(save_pc_o), 32'h0);
      chk("R1 save_status", 32'(save_status_o), 32'h0);

      for (int i = 0; i < NV; i++) begin
         rpt_end_i = 16'h7777; brk_addr_i = 16'h7777;
         do_ctl(16'h0, 16'h0);
         do_retire(1'b1, VEC[i].pc0);
         do_ctl(VEC[i].cnt, VEC[i].st);
         rpt_end_i = VEC[i].rend; brk_addr_i = VEC[i].brk;
         do_retire(VEC[i].br, VEC[i].tgt);
         chk($sformatf("R4/R5/R6/R7/R8 vec%0d pc", i), 32'(pc_o), 32'(VEC[i].e_pc));
         chk($sformatf("R5/R6/R7/R8 vec%0d count", i), 32'(rpt_count_o), 32'(VEC[i].e_cnt));
         chk($sformatf("R6/R9 vec%0d status", i), 32'(status_o), 32'(VEC[i].e_st));
         chk($sformatf("R8 vec%0d trap", i), 32'(trap_o), 32'(VEC[i].e_trap));
         if (i == 5) begin
            chk("R9 save_pc", 32'(save_pc_o), 32'h0220);
            chk("R9 save_status", 32'(save_status_o), 32'h9001);
            @(negedge clk);
            chk("R8 trap one cycle", 32'(trap_o), 32'h0);
            chk("R2 pc held", 32'(pc_o), 32'(TVEC));
         end
      end

      // R3: control write beats a same-cycle retire with branch
      rpt_end_i = 16'h7777; brk_addr_i = 16'h7777;
      do_retire(1'b1, 16'h0400);
      @(negedge clk);
      ctl_we_i = 1'b1; ctl_count_i = 16'h0009; ctl_status_i = 16'h8000;
      retire_i = 1'b1; br_taken_i = 1'b1; br_target_i = 16'h0999;
      @(negedge clk);
      ctl_we_i = 1'b0; retire_i = 1'b0; br_taken_i = 1'b0;
      chk("R3 pc unchanged", 32'(pc_o), 32'h0400);
      chk("R3 count loaded", 32'(rpt_count_o), 32'h0009);
      chk("R3 status loaded", 32'(status_o), 32'h8000);

      // R2: idle cycles change nothing
      repeat (3) @(negedge clk);
      chk("R2 pc idle", 32'(pc_o), 32'h0400);
      chk("R2 count idle", 32'(rpt_count_o), 32'h0009);

      // R5 R6: three-pass loop over 0x0100..0x0102
      do_ctl(16'h0, 16'h0);
      do_retire(1'b1, LOOP_START);
      rpt_end_i = 16'h0102;
      do_ctl(16'h0003, 16'h0001);
      for (int k = 0; k < 5; k++) do_retire(1'b0, 16'h0);
      chk("R5 second pass pc", 32'(pc_o), 32'h0102);
      chk("R5 second pass count", 32'(rpt_count_o), 32'h0002);
      for (int k = 0; k < 4; k++) do_retire(1'b0, 16'h0);
      chk("R6 loop exit pc", 32'(pc_o), 32'h0103);
      chk("R6 loop exit count", 32'(rpt_count_o), 32'h0);
      chk("R6 loop exit flag", 32'(status_o), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule